// File: doc/BRIEF.md
# Table Lookup Unit with Gated Carry Capture

This block carries out the table-reference operation of a small 4-bit controller. On a lookup request it forms a program-ROM address from a page operand, the data register and the accumulator, and fetches one ROM word. The word is DATA_W+1 bits wide. The low DATA_W bits come back as two half-width data values. The top bit goes to the carry flag only while a capture-enable flag is on.

The capture-enable flag is sticky. A dedicated set instruction turns it on. Reset turns it off, and so does waking from the low-power data-retention mode. No instruction can clear it.

A lookup borrows one level of the return stack. In its first cycle it pushes the current program counter and issues the ROM read. In its second cycle it writes the results, pops the stack and presents the saved program counter for restoration. Subroutine calls and returns share the same stack. The stack wraps around, so a lookup made at full depth overwrites the oldest entry.

Top module: `tlu_top`

## Requirements
- R1: After reset the enable flag is 0, carry is 0, both data halves are 0, the stack pointer is DEPTH-1, busy is 0 and no restore is presented.
- R2: In the cycle a lookup is accepted, rom_en_o is 1 and rom_addr_o equals {page_i, dr_i, acc_i}, with page_i in the most significant bits and acc_i in the least significant bits.
- R3: After the second clock edge of a lookup, lo_o holds ROM word bits [DATA_W/2-1:0] and hi_o holds bits [DATA_W-1:DATA_W/2].
- R4: While the enable flag is 0, a lookup ignores ROM bit DATA_W and leaves carry at its prior value.
- R5: While the enable flag is 1, a lookup loads ROM bit DATA_W into carry at its second clock edge.
- R6: A pulse on en_set_i sets the enable flag to 1. The flag stays 1 until wake_i or reset clears it, and wake_i takes priority over en_set_i.
- R7: A lookup pushes pc_i. During its second cycle, pc_ret_o shows that value with pc_ret_vld_o at 1. The stack pointer is back at its prior value afterwards.
- R8: A lookup takes exactly two cycles, and busy_o is 1 only in the second cycle. A request made while busy is ignored.
- R9: The stack holds DEPTH entries and wraps around. A push made at pointer DEPTH-1 writes entry 0 and overwrites it.
- R10: Outside a lookup's second cycle, cy_load_i writes cy_val_i into carry on the next edge. When idle, call_i pushes pc_i. ret_i, when neither call_i nor a lookup request is present, presents the top entry on pc_ret_o with pc_ret_vld_o and then pops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Wake from the low-power mode; clears the enable flag |
| tbl_req_i | input | 1 | Table lookup request |
| en_set_i | input | 1 | Set-enable instruction |
| page_i | input | PAGE_W | Page operand |
| dr_i | input | DR_W | Data register contents |
| acc_i | input | ACC_W | Accumulator contents |
| pc_i | input | PC_W | Current program counter |
| call_i | input | 1 | Subroutine call (push pc_i) |
| ret_i | input | 1 | Subroutine return (pop) |
| cy_load_i | input | 1 | Carry write from the ALU |
| cy_val_i | input | 1 | Carry value from the ALU |
| rom_en_o | output | 1 | ROM read strobe |
| rom_addr_o | output | PAGE_W+DR_W+ACC_W | ROM address |
| rom_data_i | input | DATA_W+1 | ROM word, valid one cycle after the strobe |
| lo_o | output | DATA_W/2 | Low half of the fetched word |
| hi_o | output | DATA_W/2 | High half of the fetched word |
| cy_o | output | 1 | Carry flag |
| en_o | output | 1 | Capture-enable flag |
| busy_o | output | 1 | Second cycle of a lookup |
| pc_ret_o | output | PC_W | Program counter to restore |
| pc_ret_vld_o | output | 1 | pc_ret_o is valid |
| sp_o | output | $clog2(DEPTH) | Stack pointer |

## Verification
The bench builds the block with its default parameters: a 2-bit page, a 3-bit data register, a 4-bit accumulator, an 8+1-bit word, a 10-bit program counter and a 4-entry stack. This gives a 512-word ROM that the bench fills from a formula, so lookups land on words with either value of the top bit. With four stack levels, the wrap-around overwrite is reached after four calls plus one lookup. Each lookup's carry result is checked both before and after the enable flag is set, and again after a wake clears it.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  typedef enum logic {TLU_IDLE = 1'b0, TLU_FETCH = 1'b1} tlu_state_e;
endpackage

// File: rtl/tlu_seq.sv
module tlu_seq
  import tlu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic start_o,
  output logic busy_o
);
  tlu_state_e state_q;

  assign start_o = (state_q == TLU_IDLE) && req_i;
  assign busy_o  = (state_q == TLU_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TLU_IDLE;
    else if (start_o) state_q <= TLU_FETCH;
    else state_q <= TLU_IDLE;
  end

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_o);
  p_two_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);
endmodule

// File: rtl/tlu_stack.sv
module tlu_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic [W-1:0]             din_i,
  output logic [W-1:0]             top_o,
  output logic [$clog2(DEPTH)-1:0] sp_o
);
  localparam int SP_W = $clog2(DEPTH);

  logic [W-1:0]    mem_q [DEPTH];
  logic [SP_W-1:0] sp_q;

  function automatic logic [SP_W-1:0] ptr_inc(input logic [SP_W-1:0] p);
    return (p == SP_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [SP_W-1:0] ptr_dec(input logic [SP_W-1:0] p);
    return (p == '0) ? SP_W'(DEPTH-1) : p - 1'b1;
  endfunction

  logic [SP_W-1:0] sp_up;
  assign sp_up = ptr_inc(sp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_W'(DEPTH-1);
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[sp_up] <= din_i;
      sp_q         <= sp_up;
    end else if (pop_i) begin
      sp_q <= ptr_dec(sp_q);
    end
  end

  assign top_o = mem_q[sp_q];
  assign sp_o  = sp_q;

  p_push_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && (sp_o == SP_W'(DEPTH-1)) |=> sp_o == '0);
  p_push_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_o == $past(din_i));
endmodule

// File: rtl/tlu_enflag.sv
module tlu_enflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= 1'b0;
    else if (clr_i) en_o <= 1'b0;
    else if (set_i) en_o <= 1'b1;
  end

  p_en_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_o && !clr_i |=> en_o);
  p_en_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !en_o);
endmodule

// File: rtl/tlu_top.sv
module tlu_top #(
  parameter int PAGE_W = 2,
  parameter int DR_W   = 3,
  parameter int ACC_W  = 4,
  parameter int DATA_W = 8,
  parameter int PC_W   = 10,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wake_i,
  input  logic                          tbl_req_i,
  input  logic                          en_set_i,
  input  logic [PAGE_W-1:0]             page_i,
  input  logic [DR_W-1:0]               dr_i,
  input  logic [ACC_W-1:0]              acc_i,
  input  logic [PC_W-1:0]               pc_i,
  input  logic                          call_i,
  input  logic                          ret_i,
  input  logic                          cy_load_i,
  input  logic                          cy_val_i,
  output logic                          rom_en_o,
  output logic [PAGE_W+DR_W+ACC_W-1:0]  rom_addr_o,
  input  logic [DATA_W:0]               rom_data_i,
  output logic [DATA_W/2-1:0]           lo_o,
  output logic [DATA_W/2-1:0]           hi_o,
  output logic                          cy_o,
  output logic                          en_o,
  output logic                          busy_o,
  output logic [PC_W-1:0]               pc_ret_o,
  output logic                          pc_ret_vld_o,
  output logic [$clog2(DEPTH)-1:0]      sp_o
);
  localparam int AW     = PAGE_W + DR_W + ACC_W;
  localparam int WORD_W = DATA_W + 1;
  localparam int HALF   = DATA_W / 2;

  function automatic logic [AW-1:0] form_addr(input logic [PAGE_W-1:0] pg,
                                               input logic [DR_W-1:0] dr,
                                               input logic [ACC_W-1:0] ac);
    return {pg, dr, ac};
  endfunction

  function automatic logic [HALF-1:0] low_half(input logic [WORD_W-1:0] w);
    return w[HALF-1:0];
  endfunction

  function automatic logic [HALF-1:0] high_half(input logic [WORD_W-1:0] w);
    return w[DATA_W-1:HALF];
  endfunction

  // Named internal events
  logic tbl_start, tbl_finish, call_ok, ret_ok, stk_push, stk_pop;
  logic [PC_W-1:0] stk_top;

  tlu_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (tbl_req_i),
    .start_o (tbl_start),
    .busy_o  (tbl_finish)
  );

  tlu_enflag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (en_set_i),
    .clr_i (wake_i),
    .en_o  (en_o)
  );

  assign call_ok  = call_i && !tbl_finish && !tbl_req_i;
  assign ret_ok   = ret_i && !tbl_finish && !tbl_req_i && !call_i;
  assign stk_push = tbl_start || call_ok;
  assign stk_pop  = tbl_finish || ret_ok;

  tlu_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (stk_push),
    .pop_i  (stk_pop),
    .din_i  (pc_i),
    .top_o  (stk_top),
    .sp_o   (sp_o)
  );

  assign rom_en_o     = tbl_start;
  assign rom_addr_o   = form_addr(page_i, dr_i, acc_i);
  assign busy_o       = tbl_finish;
  assign pc_ret_o     = stk_top;
  assign pc_ret_vld_o = stk_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_o <= '0;
      hi_o <= '0;
      cy_o <= 1'b0;
    end else if (tbl_finish) begin
      lo_o <= low_half(rom_data_i);
      hi_o <= high_half(rom_data_i);
      if (en_o) cy_o <= rom_data_i[WORD_W-1];
    end else if (cy_load_i) begin
      cy_o <= cy_val_i;
    end
  end

  p_lo_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_finish |=> lo_o == $past(rom_data_i[HALF-1:0]));
  p_carry_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_finish && !en_o |=> $stable(cy_o));
  p_carry_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_finish && en_o |=> cy_o == $past(rom_data_i[WORD_W-1]));
  p_sp_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_finish |=> sp_o == $past(sp_o, 2));
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tbl_start && tbl_finish));
endmodule

// File: tb/tlu_top_bench.sv
`timescale 1ns/1ps
module tlu_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_i = 0, tbl_req_i = 0, en_set_i = 0, call_i = 0, ret_i = 0;
  logic cy_load_i = 0, cy_val_i = 0;
  logic [1:0] page_i = 0;
  logic [2:0] dr_i = 0;
  logic [3:0] acc_i = 0;
  logic [9:0] pc_i = 0;
  logic       rom_en_o;
  logic [8:0] rom_addr_o;
  logic [8:0] rom_q = 0;
  logic [3:0] lo_o, hi_o;
  logic       cy_o, en_o, busy_o, pc_ret_vld_o;
  logic [9:0] pc_ret_o;
  logic [1:0] sp_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlu_top u_tlu_top (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .tbl_req_i(tbl_req_i),
    .en_set_i(en_set_i), .page_i(page_i), .dr_i(dr_i), .acc_i(acc_i),
    .pc_i(pc_i), .call_i(call_i), .ret_i(ret_i), .cy_load_i(cy_load_i),
    .cy_val_i(cy_val_i), .rom_en_o(rom_en_o), .rom_addr_o(rom_addr_o),
    .rom_data_i(rom_q), .lo_o(lo_o), .hi_o(hi_o), .cy_o(cy_o), .en_o(en_o),
    .busy_o(busy_o), .pc_ret_o(pc_ret_o), .pc_ret_vld_o(pc_ret_vld_o),
    .sp_o(sp_o)
  );

  function automatic logic [8:0] romf(input logic [8:0] a);
    return 9'((a * 37 + 5) ^ (a >> 2));
  endfunction

  always_ff @(posedge clk) if (rom_en_o) rom_q <= romf(rom_addr_o);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cy(input logic v);
    @(negedge clk); cy_load_i = 1; cy_val_i = v;
    @(negedge clk); cy_load_i = 0;
  endtask

  // Starts at a negedge; returns at the negedge after the second edge.
  task automatic lookup(input logic [1:0] pg, input logic [2:0] dr,
                        input logic [3:0] ac, input logic [9:0] pc,
                        input logic exp_cy, input logic [1:0] exp_sp);
    logic [8:0] a;
    logic [8:0] w;
    a = {pg, dr, ac};
    w = romf(a);
    page_i = pg; dr_i = dr; acc_i = ac; pc_i = pc; tbl_req_i = 1;
    #1;
    check(rom_en_o === 1'b1 && rom_addr_o === a, "R2 address", int'(rom_addr_o), int'(a));
    @(negedge clk);
    tbl_req_i = 0;
    check(busy_o === 1'b1, "R8 busy", int'(busy_o), 1);
    check(pc_ret_o === pc && pc_ret_vld_o === 1'b1, "R7 saved pc", int'(pc_ret_o), int'(pc));
    @(negedge clk);
    check(lo_o === w[3:0], "R3 low half", int'(lo_o), int'(w[3:0]));
    check(hi_o === w[7:4], "R3 high half", int'(hi_o), int'(w[7:4]));
    check(cy_o === exp_cy, "R4/R5 carry", int'(cy_o), int'(exp_cy));
    check(sp_o === exp_sp, "R7 sp restored", int'(sp_o), int'(exp_sp));
  endtask

  // page, dr, acc, pc
  localparam logic [18:0] VEC [6] = '{
    {2'd0, 3'd0, 4'd0,  10'd17},
    {2'd1, 3'd5, 4'd9,  10'd300},
    {2'd2, 3'd7, 4'd15, 10'd511},
    {2'd3, 3'd2, 4'd6,  10'd1023},
    {2'd3, 3'd7, 4'd15, 10'd64},
    {2'd1, 3'd3, 4'd1,  10'd5}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(en_o === 0 && cy_o === 0, "R1 flags", int'({en_o, cy_o}), 0);
    check(sp_o === 2'd3, "R1 sp", int'(sp_o), 3);
    check(lo_o === 0 && hi_o === 0 && busy_o === 0 && pc_ret_vld_o === 0,
          "R1 outputs", int'({lo_o, hi_o, busy_o, pc_ret_vld_o}), 0);

    // R10 carry load from ALU
    load_cy(1'b1);
    check(cy_o === 1'b1, "R10 carry load", int'(cy_o), 1);

    // Pass A: enable off, carry must hold (R4)
    foreach (VEC[i]) begin
      logic v;
      v = i[0];
      load_cy(v);
      @(negedge clk);
      lookup(VEC[i][18:17], VEC[i][16:14], VEC[i][13:10], VEC[i][9:0], v, 2'd3);
    end

    // R6 set
    @(negedge clk); en_set_i = 1;
    @(negedge clk); en_set_i = 0;
    check(en_o === 1'b1, "R6 set", int'(en_o), 1);
    load_cy(1'b0);
    repeat (3) @(negedge clk);
    check(en_o === 1'b1, "R6 sticky", int'(en_o), 1);

    // Pass B: enable on, carry copies bit 8 (R5)
    foreach (VEC[i]) begin
      logic [8:0] w;
      w = romf({VEC[i][18:17], VEC[i][16:14], VEC[i][13:10]});
      load_cy(~w[8]);
      @(negedge clk);
      lookup(VEC[i][18:17], VEC[i][16:14], VEC[i][13:10], VEC[i][9:0], w[8], 2'd3);
    end

    // R6 wake clears, with priority over set
    @(negedge clk); wake_i = 1; en_set_i = 1;
    @(negedge clk); wake_i = 0; en_set_i = 0;
    check(en_o === 1'b0, "R6 wake clears", int'(en_o), 0);
    begin
      logic [8:0] w;
      w = romf({2'd2, 3'd7, 4'd15});
      load_cy(~w[8]);
      @(negedge clk);
      lookup(2'd2, 3'd7, 4'd15, 10'd99, ~w[8], 2'd3);  // R4 after wake
    end

    // R8: request held through busy cycle is ignored
    @(negedge clk);
    page_i = 1; dr_i = 1; acc_i = 1; pc_i = 10'd77; tbl_req_i = 1;
    @(negedge clk);
    check(busy_o === 1'b1, "R8 busy second cycle", int'(busy_o), 1);
    @(negedge clk);
    tbl_req_i = 0;
    check(busy_o === 1'b0, "R8 request ignored while busy", int'(busy_o), 0);
    check(sp_o === 2'd3, "R8 sp after ignored request", int'(sp_o), 3);
    @(negedge clk);

    // R9: four calls fill the stack, lookup wraps and overwrites entry 0
    for (int k = 0; k < 4; k++) begin
      pc_i = 10'(100 + k); call_i = 1;
      @(negedge clk);
      call_i = 0;
      check(sp_o === 2'(k), "R10 call push sp", int'(sp_o), k);
    end
    lookup(2'd0, 3'd1, 4'd2, 10'd200, cy_o, 2'd3);
    for (int k = 3; k >= 0; k--) begin
      int exp_pc;
      exp_pc = (k == 0) ? 200 : 100 + k;
      ret_i = 1;
      #1;
      check(pc_ret_o === 10'(exp_pc) && pc_ret_vld_o === 1'b1, "R9 return order",
            int'(pc_ret_o), exp_pc);
      @(negedge clk);
      ret_i = 0;
    end
    check(sp_o === 2'd3, "R9 sp after unwinding", int'(sp_o), 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule